// File: doc/BRIEF.md
# ADC Parallel Result Word Multiplexer

This block is the device-side output stage of an 18-bit converter. It keeps the most recent conversion result in a register and presents it on an 18-pin data bus. The pad ring implements the tri-state buffers. The block supplies the pin values (`db_out`) and a single enable (`db_oe`) that turns the pads on. Two format selects pick which slice of the result reaches which pins. A host with an 18-bit bus reads the whole word at once. A 16-bit host reads the upper sixteen bits and then fetches the two low bits. An 8-bit host needs up to three reads. In every partial format, the pins that carry no result bits are driven to logic one.

The bus is enabled only while chip-select and read are both asserted (active low). The pin values follow the format selects combinationally, so a host may hold read low and walk through the formats without toggling the strobe. A monitor watches the conversion-start input and reports any read that falls inside a quiet window around its falling edge. The window is given in picoseconds and converted to clock cycles, rounding up. The result register changes only on a load strobe, which a test stub supplies in place of the conversion engine. Every control and data pin is a plain signal. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `adc_word_mux`

## Requirements
- R1: `db_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. Whenever `db_oe` is 0, `db_out` is all zeros.
- R2: With `byte_sel`=0 and `bus_sel`=0 during a read, `db_out[17:0]` equals result bits 17..0 in the same positions.
- R3: With `byte_sel`=0 and `bus_sel`=1 during a read, `db_out[3:2]` carries result bits 1..0 and every other pin is 1.
- R4: With `byte_sel`=1 and `bus_sel`=0 during a read, `db_out[17:10]` carries result bits 9..2 and pins 9..0 are 1.
- R5: With `byte_sel`=1 and `bus_sel`=1 during a read, `db_out[11:10]` carries result bits 1..0 and every other pin is 1.
- R6: While the read stays active, a change of `byte_sel` or `bus_sel` changes `db_out` in the same cycle, with no clock edge needed.
- R7: The result register resets to zero and takes `load_data` only at a rising clock edge where `load_en` is 1. A change of `load_data` at any other time leaves the output unchanged.
- R8: Let the falling edge of `conv_start` be sampled at clock edge k. If a read is active at any edge from k−PRE to k, `quiet_viol` is 1 for the cycle after edge k. PRE is ceil(QUIET_PRE_PS / CLK_PERIOD_PS).
- R9: If a read is active at any edge from k+1 to k+POST, `quiet_viol` is 1 for the cycle after that edge. POST is ceil(QUIET_POST_PS / CLK_PERIOD_PS).
- R10: A read that is more than PRE edges before, or more than POST edges after, a sampled falling edge of `conv_start` leaves `quiet_viol` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load strobe for the result register |
| load_data | input | W | Result value captured on `load_en` |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | Format select: byte half |
| bus_sel | input | 1 | Format select: low-tail fetch |
| conv_start | input | 1 | Conversion start; its falling edge opens the quiet window |
| db_out | output | W | Pin values for the data bus |
| db_oe | output | 1 | Enable for the data-bus pad drivers |
| quiet_viol | output | 1 | One-cycle pulse for each read edge inside the quiet window |

## Verification
The bench builds the block with its default parameters: an 18-bit word, a 4000 ps clock period, and windows of 50000 ps and 40000 ps. These give PRE = 13 and POST = 10 cycles. With windows that short, the bench can place a single read exactly on each window edge and one cycle beyond it, in both directions, within a few dozen cycles. The 18-bit width matches the fixed pin map of the four formats, so each slice position and each all-ones fill is compared against an independently written pin map.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

  // Format code is {byte_sel, bus_sel}
  typedef enum logic [1:0] {
    FMT_WIDE   = 2'b00,
    FMT_TAIL16 = 2'b01,
    FMT_MID8   = 2'b10,
    FMT_TAIL8  = 2'b11
  } fmt_e;

  function automatic int unsigned cycles_up(input int unsigned span_ps,
                                            input int unsigned period_ps);
    return (span_ps + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_en) word_q <= load_data;
  end

endmodule

// File: rtl/adc_slice_steer.sv
module adc_slice_steer
  import adc_mux_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] word,
  input  fmt_e         fmt,
  output logic [W-1:0] pins
);

  localparam int TAIL   = W - 16;     // bits left over after a 16-bit read
  localparam int BYTE_W = 8;
  localparam int HI_LO  = W - BYTE_W; // lowest pin of the upper byte

  generate
    if (TAIL < 1) begin : g_bad_width
      initial $fatal(1, "adc_slice_steer needs W >= 17");
    end
  endgenerate

  always_comb begin
    pins = '1;
    unique case (fmt)
      FMT_WIDE:   pins = word;
      FMT_TAIL16: pins[2*TAIL-1:TAIL]       = word[TAIL-1:0];
      FMT_MID8:   pins[W-1:HI_LO]           = word[HI_LO-1:TAIL];
      FMT_TAIL8:  pins[HI_LO+TAIL-1:HI_LO]  = word[TAIL-1:0];
      default:    pins = '1;
    endcase
  end

endmodule

// File: rtl/adc_quiet_monitor.sv
module adc_quiet_monitor #(
  parameter int PRE_CYC  = 13,
  parameter int POST_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic rd_act,
  output logic viol
);

  localparam int GW = $clog2(PRE_CYC + 1);
  localparam int PW = $clog2(POST_CYC + 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(PRE_CYC);
  localparam logic [PW-1:0] POST_TOP = PW'(POST_CYC);

  logic          conv_q;
  logic [GW-1:0] gap_q;   // edges since last read edge, minus one
  logic [PW-1:0] post_q;  // edges left in the post window
  logic          fall, pre_hit, post_hit;

  assign fall     = conv_q & ~conv_start;
  assign pre_hit  = fall & (rd_act | (gap_q < GAP_MAX));
  assign post_hit = (post_q != '0) & rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      gap_q  <= GAP_MAX;
      post_q <= '0;
      viol   <= 1'b0;
    end else begin
      conv_q <= conv_start;
      if (rd_act)              gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
      if (fall)                post_q <= POST_TOP;
      else if (post_q != '0)   post_q <= post_q - 1'b1;
      viol <= pre_hit | post_hit;
    end
  end

endmodule

// File: rtl/adc_word_mux.sv
module adc_word_mux
  import adc_mux_pkg::*;
#(
  parameter int W             = 18,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int QUIET_PRE_PS  = 50000,
  parameter int QUIET_POST_PS = 40000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         byte_sel,
  input  logic         bus_sel,
  input  logic         conv_start,
  output logic [W-1:0] db_out,
  output logic         db_oe,
  output logic         quiet_viol
);

  localparam int PRE_CYC  = int'(cycles_up(QUIET_PRE_PS, CLK_PERIOD_PS));
  localparam int POST_CYC = int'(cycles_up(QUIET_POST_PS, CLK_PERIOD_PS));

  logic [W-1:0] word_q;
  logic [W-1:0] steered;
  logic         rd_act;
  fmt_e         fmt;

  assign rd_act = ~cs_n & ~rd_n;
  assign fmt    = fmt_e'({byte_sel, bus_sel});

  adc_result_reg #(.W(W)) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (load_data),
    .word_q    (word_q)
  );

  adc_slice_steer #(.W(W)) u_steer (
    .word (word_q),
    .fmt  (fmt),
    .pins (steered)
  );

  adc_quiet_monitor #(.PRE_CYC(PRE_CYC), .POST_CYC(POST_CYC)) u_quiet (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .rd_act     (rd_act),
    .viol       (quiet_viol)
  );

  assign db_oe  = rd_act;
  assign db_out = rd_act ? steered : '0;

endmodule

// File: rtl/adc_word_mux_chk.sv
module adc_word_mux_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_en,
  input logic         cs_n,
  input logic         rd_n,
  input logic         byte_sel,
  input logic         bus_sel,
  input logic         conv_start,
  input logic [W-1:0] word_q,
  input logic [W-1:0] db_out,
  input logic         db_oe,
  input logic         quiet_viol
);

  logic rd_on, wide_rd;
  assign rd_on   = !cs_n && !rd_n;
  assign wide_rd = rd_on && !byte_sel && !bus_sel;

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_on |-> (!db_oe && db_out == '0));

  p_full_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wide_rd |-> db_out == word_q);

  p_tail16_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && !byte_sel && bus_sel) |-> (&db_out[W-1:4] && &db_out[1:0]));

  p_mid8_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && byte_sel && !bus_sel) |-> &db_out[9:0]);

  p_tail8_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && byte_sel && bus_sel) |-> (&db_out[W-1:12] && &db_out[9:0]));

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_rd && $past(wide_rd) && !$past(load_en)) |-> $stable(db_out));

  p_fall_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_start) && rd_on) |=> quiet_viol);

  p_no_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_on && !$fell(conv_start)) |=> !quiet_viol);

endmodule

bind adc_word_mux adc_word_mux_chk #(.W(W)) u_chk (.*);

// File: tb/adc_word_mux_test.sv
`timescale 1ns/1ps
module adc_word_mux_test;

  localparam int W    = 18;
  localparam int PRE  = 13;
  localparam int POST = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_data = '0;
  logic         cs_n = 1'b1, rd_n = 1'b1;
  logic         byte_sel = 1'b0, bus_sel = 1'b0;
  logic         conv_start = 1'b1;
  logic [W-1:0] db_out;
  logic         db_oe, quiet_viol;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  adc_word_mux uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel), .bus_sel(bus_sel),
    .conv_start(conv_start), .db_out(db_out), .db_oe(db_oe),
    .quiet_viol(quiet_viol)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pin_map(input logic [W-1:0] d,
                                           input logic b, input logic s);
    case ({b, s})
      2'b00:   return d;
      2'b01:   return {14'h3FFF, d[1:0], 2'b11};
      2'b10:   return {d[9:2], 10'h3FF};
      default: return {6'h3F, d[1:0], 10'h3FF};
    endcase
  endfunction

  task automatic load_word(input logic [W-1:0] v);
    @(negedge clk); load_data = v; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic set_rd(input logic on);
    cs_n = ~on; rd_n = ~on;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 idle oe", W'(db_oe), '0);
    check("R1 idle pins", db_out, '0);
    check("R10 idle viol", W'(quiet_viol), '0);
    set_rd(1); #1;
    check("R7 reset word", db_out, '0);
    set_rd(0);
  endtask

  task automatic t_gate;
    load_word(18'h2B3C5);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
    check("R1 cs only oe", W'(db_oe), '0);
    check("R1 cs only pins", db_out, '0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    check("R1 rd only oe", W'(db_oe), '0);
    check("R1 rd only pins", db_out, '0);
    cs_n = 1'b0; #1;
    check("R1 both oe", W'(db_oe), 18'd1);
    set_rd(0);
  endtask

  task automatic t_formats(input logic [W-1:0] v);
    load_word(v);
    @(negedge clk); set_rd(1);
    byte_sel = 0; bus_sel = 0; #1; check("R2 wide", db_out, pin_map(v, 0, 0));
    byte_sel = 0; bus_sel = 1; #1; check("R3 tail16", db_out, pin_map(v, 0, 1));
    byte_sel = 1; bus_sel = 0; #1; check("R4 mid8", db_out, pin_map(v, 1, 0));
    byte_sel = 1; bus_sel = 1; #1; check("R5 tail8", db_out, pin_map(v, 1, 1));
    set_rd(0); byte_sel = 0; bus_sel = 0;
  endtask

  task automatic t_autoread;
    load_word(18'h1A5E7);
    @(negedge clk); set_rd(1); #1;
    check("R6 first", db_out, pin_map(18'h1A5E7, 0, 0));
    byte_sel = 1; #0.5;
    check("R6 byte flip", db_out, pin_map(18'h1A5E7, 1, 0));
    bus_sel = 1; #0.5;
    check("R6 bus flip", db_out, pin_map(18'h1A5E7, 1, 1));
    @(negedge clk); set_rd(0); byte_sel = 0; bus_sel = 0;
  endtask

  task automatic t_hold;
    load_word(18'h0F0F3);
    @(negedge clk); load_data = 18'h30C0C; set_rd(1);
    @(negedge clk);
    check("R7 no strobe", db_out, 18'h0F0F3);
    load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
    check("R7 strobe", db_out, 18'h30C0C);
    set_rd(0);
  endtask

  task automatic settle;
    conv_start = 1'b1; set_rd(0);
    repeat (PRE + POST + 4) @(negedge clk);
  endtask

  // Read on one edge, then fall of conv_start sampled j edges later
  task automatic t_pre(input int j, input logic exp);
    settle();
    set_rd(1); @(negedge clk); set_rd(0);
    repeat (j - 1) @(negedge clk);
    conv_start = 1'b0;
    @(negedge clk);
    check(exp ? "R8 pre edge hit" : "R10 pre beyond", W'(quiet_viol), W'(exp));
  endtask

  // Fall sampled at edge k, read on edge k+j
  task automatic t_post(input int j, input logic exp);
    settle();
    conv_start = 1'b0;
    @(negedge clk);
    check("R10 fall alone", W'(quiet_viol), '0);
    repeat (j - 1) @(negedge clk);
    set_rd(1);
    @(negedge clk); set_rd(0);
    check(exp ? "R9 post edge hit" : "R10 post beyond", W'(quiet_viol), W'(exp));
    @(negedge clk);
    check("R9 pulse width", W'(quiet_viol), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_formats(18'h2A5C3);
    t_formats(18'h15A3C);
    t_formats(18'h3FFFE);
    t_formats(18'h00001);
    t_autoread();
    t_hold();
    t_pre(PRE, 1'b1);
    t_pre(PRE + 1, 1'b0);
    t_pre(1, 1'b1);
    t_post(POST, 1'b1);
    t_post(POST + 1, 1'b0);
    t_post(1, 1'b1);
    settle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #600000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule